// File: doc/BRIEF.md
# Page Buffer Merge Engine

This block holds the byte buffer that sits behind a paged serial flash command decoder. A command opens with a start pulse that carries a mode bit and an address. The upper address bits choose a page and the lower bits choose where in that page the first byte lands. Data bytes then stream in one per clock. Each byte goes into the buffer at a running offset that wraps inside the page, and a per-byte mask records which offsets were sent.

When the end pulse arrives, the block commits the buffer into a small behavioural page array. It does this one byte per clock. In replace mode it first fills the unsent buffer slots from the array, then erases the page to all ones, then programs it from the buffer. In clear-only mode it ANDs the new bytes into the stored ones. A busy flag covers the whole commit for a parameterised number of clocks, which is longer in replace mode. Serial decoding and sector protection are handled upstream. The array has a combinational read port so its contents can be observed.

Top module: `page_merge_engine`

## Requirements
- R1: A command accepted with address A targets page A[ADDR_W-1:OFF_W], and its first data byte lands at offset A[OFF_W-1:0], where OFF_W = log2(PAGE_BYTES).
- R2: Each further byte goes to the next offset. After offset PAGE_BYTES-1 the offset wraps to 0 of the same page; no other page is touched.
- R3: When more than PAGE_BYTES bytes arrive, a later byte overwrites the earlier byte at the same offset, so only the newest byte per offset is committed.
- R4: With cmd_mode_i = 1 (replace), each sent offset ends up holding exactly the last byte sent to it. Bits may go from 0 to 1 as well as from 1 to 0, because the page is erased before it is programmed.
- R5: With cmd_mode_i = 0 (clear-only), each sent offset ends up holding the old stored byte ANDed with the new byte.
- R6: Offsets that were not sent, and all other pages, keep their previous contents in both modes.
- R7: busy_o rises in the clock after the end pulse is accepted. It stays high for exactly WR_EFF clocks in replace mode and PG_EFF clocks in clear-only mode, where WR_EFF = max(WR_CYCLES, 3*PAGE_BYTES+1) and PG_EFF = max(PG_CYCLES, PAGE_BYTES+1).
- R8: While busy_o is high, cmd_start_i, data_valid_i and cmd_end_i are ignored. No second commit follows, and no page changes beyond the running command.
- R9: An end pulse with no data byte since the start returns the block to idle with no busy and no change. Data or end pulses outside an open command are ignored.
- R10: During and straight after reset, busy_o is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Opens a command (accepted only when idle) |
| cmd_mode_i | input | 1 | 1 = replace (erase then program), 0 = clear-only (AND) |
| cmd_addr_i | input | ADDR_W | Page index and start offset |
| data_valid_i | input | 1 | A data byte is present on data_i |
| data_i | input | DATA_W | Data byte |
| cmd_end_i | input | 1 | Closes the command and starts the commit |
| busy_o | output | 1 | Commit in progress |
| rd_addr_i | input | ADDR_W | Array observation address |
| rd_data_o | output | DATA_W | Array byte at rd_addr_i |

## Verification
The bench sweeps every start offset with lengths of one byte, a few bytes, exactly a page, one past a page, and over two pages, in both modes. It compares every byte of every page against a model after each commit. A design that forgot to wrap would write into the next page, and one that kept the oldest bytes would leave stale data after the long runs. A missing fill pass would erase untouched bytes to all ones. A missing erase would leave set bits that replace mode must clear, and a missing AND would let clear-only mode set bits. Each busy window is counted against the clamped cycle count. One case injects a full command during busy to catch a block that queues or starts a second commit, and the zero-byte and stray-pulse cases catch spurious commits.

// File: rtl/pme_pkg.sv
package pme_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FILL,
    ST_ERASE,
    ST_PROG,
    ST_WAIT
  } pme_state_e;

  localparam logic MODE_CLEAR   = 1'b0;
  localparam logic MODE_REPLACE = 1'b1;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pme_stage.sv
// Page-wide staging buffer with a per-byte sent mask.
module pme_stage #(
  parameter int unsigned PAGE_BYTES = 256,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              any_valid_o
);

  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];

  always_comb begin
    mask_d = mask_q;
    if (clr_i) begin
      mask_d = '0;
    end else if (wr_en_i) begin
      mask_d[wr_idx_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en_i && !clr_i && (wr_idx_i == OFF_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o   = slot_q[rd_idx_i];
  assign rd_valid_o  = mask_q[rd_idx_i];
  assign any_valid_o = |mask_q;

endmodule

// File: rtl/pme_array.sv
// Behavioural page array: one write port, two combinational read ports.
module pme_array #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);

  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      cell_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = cell_q[raddr_a_i];
  assign rdata_b_o = cell_q[raddr_b_i];

endmodule

// File: rtl/pme_timer.sv
// Busy window counter: high for exactly load_val_i+1 clocks after a load.
module pme_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load_i) begin
      busy_d = 1'b1;
      cnt_d  = load_val_i;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);

endmodule

// File: rtl/page_merge_engine.sv
// Page buffer merge engine: collect a byte stream into a page buffer, then
// commit it with fill/erase/program (replace) or AND (clear-only).
module page_merge_engine
  import pme_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 256,
  parameter int unsigned NUM_PAGES  = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WR_CYCLES  = 1000,
  parameter int unsigned PG_CYCLES  = 300,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PG_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int unsigned ADDR_W    = PG_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start_i,
  input  logic              cmd_mode_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cmd_end_i,
  output logic              busy_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int unsigned DEPTH  = (1 << PG_W) * PAGE_BYTES;
  localparam int unsigned WR_EFF = max_u(WR_CYCLES, 3 * PAGE_BYTES + 1);
  localparam int unsigned PG_EFF = max_u(PG_CYCLES, PAGE_BYTES + 1);
  localparam int unsigned CNT_W  = $clog2(max_u(WR_EFF, PG_EFF)) + 1;
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_EFF - 1);
  localparam logic [CNT_W-1:0] PG_LOAD = CNT_W'(PG_EFF - 1);

  // sequencer state
  pme_state_e       state_q, state_d;
  logic [PG_W-1:0]  page_q,  page_d;
  logic [OFF_W-1:0] ptr_q,   ptr_d;
  logic [OFF_W-1:0] idx_q,   idx_d;
  logic             mode_q,  mode_d;

  // inter-block nets
  logic              stage_clr, stage_we, buf_valid, buf_any;
  logic [OFF_W-1:0]  stage_widx;
  logic [DATA_W-1:0] stage_wdata, buf_rd;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata, mem_old;
  logic [ADDR_W-1:0] mem_addr;
  logic              tmr_load, tmr_last, busy;
  logic [CNT_W-1:0]  tmr_val;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    page_d    = page_q;
    ptr_d     = ptr_q;
    idx_d     = idx_q;
    mode_d    = mode_q;
    stage_clr = 1'b0;
    tmr_load  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_start_i && !busy) begin
          state_d   = ST_LOAD;
          page_d    = cmd_addr_i[ADDR_W-1:OFF_W];
          ptr_d     = cmd_addr_i[OFF_W-1:0];
          mode_d    = cmd_mode_i;
          stage_clr = 1'b1;
        end
      end
      ST_LOAD: begin
        if (data_valid_i) begin
          ptr_d = ptr_q + 1'b1;
        end
        if (cmd_end_i) begin
          if (buf_any || data_valid_i) begin
            tmr_load = 1'b1;
            idx_d    = '0;
            state_d  = (mode_q == MODE_REPLACE) ? ST_FILL : ST_PROG;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_FILL: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == '1) state_d = ST_ERASE;
      end
      ST_ERASE: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == '1) state_d = ST_PROG;
      end
      ST_PROG: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == '1) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (tmr_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
      mode_q  <= MODE_CLEAR;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
      mode_q  <= mode_d;
    end
  end

  // staging buffer: bytes in during load, array fill during the fill pass
  assign stage_we    = ((state_q == ST_LOAD) && data_valid_i)
                     || ((state_q == ST_FILL) && !buf_valid);
  assign stage_widx  = (state_q == ST_LOAD) ? ptr_q : idx_q;
  assign stage_wdata = (state_q == ST_LOAD) ? data_i : mem_old;

  pme_stage #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W)
  ) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (stage_clr),
    .wr_en_i     (stage_we),
    .wr_idx_i    (stage_widx),
    .wr_data_i   (stage_wdata),
    .rd_idx_i    (idx_q),
    .rd_data_o   (buf_rd),
    .rd_valid_o  (buf_valid),
    .any_valid_o (buf_any)
  );

  // array update: erase writes ones, program ANDs the buffer in
  assign mem_addr  = {page_q, idx_q};
  assign mem_we    = (state_q == ST_ERASE) || (state_q == ST_PROG);
  assign mem_wdata = (state_q == ST_ERASE) ? {DATA_W{1'b1}}
                   : (mem_old & (buf_valid ? buf_rd : {DATA_W{1'b1}}));

  pme_array #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_array (
    .clk       (clk),
    .we_i      (mem_we),
    .waddr_i   (mem_addr),
    .wdata_i   (mem_wdata),
    .raddr_a_i (mem_addr),
    .rdata_a_o (mem_old),
    .raddr_b_i (rd_addr_i),
    .rdata_b_o (rd_data_o)
  );

  assign tmr_val = (mode_q == MODE_REPLACE) ? WR_LOAD : PG_LOAD;

  pme_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .busy_o     (busy),
    .last_o     (tmr_last)
  );

  assign busy_o = busy;

endmodule

// File: rtl/page_merge_engine_chk.sv
module pme_checker
  import pme_pkg::*;
#(
  parameter int unsigned WR_EFF = 769,
  parameter int unsigned PG_EFF = 257,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cmd_end,
  input logic              mode,
  input pme_state_e        state,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_old,
  input logic              buf_valid
);

  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_run <= 0;
    else if (!busy) busy_run <= 0;
    else            busy_run <= busy_run + 1;
  end

  a_r7_busy_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_end));

  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (busy_run == (mode ? WR_EFF : PG_EFF)));

  a_r5_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && state == ST_PROG) |-> ((mem_wdata & ~mem_old) == '0));

  a_r6_unsent_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && state == ST_PROG && !mode && !buf_valid) |-> (mem_wdata == mem_old));

  a_r8_quiet_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_LOAD) |-> (!mem_we && !busy));

endmodule

bind page_merge_engine pme_checker #(
  .WR_EFF (WR_EFF),
  .PG_EFF (PG_EFF),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_o),
  .cmd_end   (cmd_end_i),
  .mode      (mode_q),
  .state     (state_q),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_old   (mem_old),
  .buf_valid (buf_valid)
);

// File: tb/page_merge_engine_tb.sv
module page_merge_engine_tb;

  localparam int PB  = 16;
  localparam int NP  = 4;
  localparam int DW  = 8;
  localparam int WRC = 10;
  localparam int PGC = 20;
  localparam int AW  = 6;
  localparam int WR_EXP = (WRC >= 3*PB+1) ? WRC : 3*PB+1;
  localparam int PG_EXP = (PGC >= PB+1) ? PGC : PB+1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_start, cmd_mode, data_valid, cmd_end;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [DW-1:0] data_in, rd_data;
  logic          busy;

  always #10 clk = ~clk;

  page_merge_engine #(
    .PAGE_BYTES (PB),
    .NUM_PAGES  (NP),
    .DATA_W     (DW),
    .WR_CYCLES  (WRC),
    .PG_CYCLES  (PGC)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start_i  (cmd_start),
    .cmd_mode_i   (cmd_mode),
    .cmd_addr_i   (cmd_addr),
    .data_valid_i (data_valid),
    .data_i       (data_in),
    .cmd_end_i    (cmd_end),
    .busy_o       (busy),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data)
  );

  int          n_run = 0;
  int          n_fail = 0;
  int          op_seq = 0;
  bit          done = 0;
  bit          check_en = 0;
  logic [7:0]  model [NP*PB];
  bit          sent  [NP*PB];
  string       tag_sent;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    for (int a = 0; a < NP*PB; a++) begin
      rd_addr = AW'(a);
      #1;
      chk(rd_data == model[a], sent[a] ? tag_sent : "R6 unsent byte kept",
          int'(rd_data), int'(model[a]));
    end
  endtask

  // fixval < 0 selects the generated data pattern
  task automatic do_cmd(input int pg, input int off, input int mode, input int len,
                        input bit inject, input int fixval);
    logic [7:0] bb [PB];
    bit         bv [PB];
    int         ptr, n, a, exp;
    logic [7:0] d;
    for (int i = 0; i < PB; i++) begin bv[i] = 0; bb[i] = '0; end
    for (int i = 0; i < NP*PB; i++) sent[i] = 0;
    op_seq++;
    @(negedge clk);
    cmd_start = 1'b1; cmd_addr = AW'(pg*PB + off); cmd_mode = mode[0];
    @(negedge clk);
    cmd_start = 1'b0;
    ptr = off;
    for (int k = 0; k < len; k++) begin
      d = (fixval >= 0) ? 8'(fixval) : 8'((op_seq*29 + k*13 + 7) & 255);
      data_valid = 1'b1; data_in = d;
      bb[ptr] = d; bv[ptr] = 1;
      ptr = (ptr + 1) % PB;
      @(negedge clk);
    end
    data_valid = 1'b0;
    cmd_end = 1'b1;
    @(negedge clk);
    cmd_end = 1'b0;
    for (int i = 0; i < PB; i++) begin
      if (bv[i]) begin
        a = pg*PB + i;
        model[a] = (mode != 0) ? bb[i] : (model[a] & bb[i]);
        sent[a] = 1;
      end
    end
    if (len > PB)            tag_sent = "R3 newest bytes kept";
    else if (off + len > PB) tag_sent = "R2 wrap inside page";
    else if (mode != 0)      tag_sent = "R4 replace merge";
    else                     tag_sent = "R5 clear-only merge";
    n = 0;
    while (busy && n < 5000) begin
      n++;
      if (inject) begin
        case (n)
          2: begin cmd_start = 1'b1; cmd_addr = AW'(((pg+1)%NP)*PB); cmd_mode = 1'b1; end
          3: begin cmd_start = 1'b0; data_valid = 1'b1; data_in = 8'h5A; end
          4: begin data_valid = 1'b0; cmd_end = 1'b1; end
          5: cmd_end = 1'b0;
          default: ;
        endcase
      end
      @(negedge clk);
    end
    cmd_start = 1'b0; data_valid = 1'b0; cmd_end = 1'b0;
    exp = (len == 0) ? 0 : ((mode != 0) ? WR_EXP : PG_EXP);
    if (check_en) begin
      chk(n == exp, inject ? "R8 busy length with injected command"
                           : ((len == 0) ? "R9 empty command no busy" : "R7 busy length"),
          n, exp);
      if (inject) begin
        repeat (3) begin
          @(negedge clk);
          chk(busy == 1'b0, "R8 no queued commit", int'(busy), 0);
        end
      end
      check_all();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int lens [5] = '{1, 3, 16, 17, 35};
    rst_n = 1'b0; cmd_start = 1'b0; cmd_mode = 1'b0; cmd_addr = '0;
    data_valid = 1'b0; data_in = '0; cmd_end = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy low in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R10 busy low after reset", int'(busy), 0);

    // bring every page to a known pattern with full-page replace commands
    for (int p = 0; p < NP; p++) do_cmd(p, 0, 1, PB, 0, -1);
    check_en = 1;
    tag_sent = "R4 initial page";
    check_all();

    // R1: single byte lands at the addressed page and offset
    do_cmd(2, 9, 1, 1, 0, 8'hC3);
    rd_addr = AW'(2*PB + 9); #1;
    chk(rd_data == 8'hC3, "R1 start offset and page", int'(rd_data), 8'hC3);

    // R4 / R5: bit-setting needs the erase, clear-only must not set bits
    do_cmd(1, 5, 1, 1, 0, 8'h0F);
    do_cmd(1, 5, 1, 1, 0, 8'hF0);
    rd_addr = AW'(1*PB + 5); #1;
    chk(rd_data == 8'hF0, "R4 replace sets bits", int'(rd_data), 8'hF0);
    do_cmd(1, 5, 0, 1, 0, 8'h3C);
    rd_addr = AW'(1*PB + 5); #1;
    chk(rd_data == 8'h30, "R5 clear-only ANDs", int'(rd_data), 8'h30);

    // sweep of offsets, lengths and modes
    for (int off = 0; off < PB; off++) begin
      for (int li = 0; li < 5; li++) begin
        do_cmd((off + li) % NP, off, (off + li) % 2, lens[li], 0, -1);
      end
    end

    // R8: full command injected while busy, both modes
    do_cmd(3, 4, 1, 5, 1, -1);
    do_cmd(0, 12, 0, 7, 1, -1);

    // R9: empty command and stray pulses while idle
    do_cmd(2, 3, 1, 0, 0, -1);
    @(negedge clk);
    data_valid = 1'b1; data_in = 8'h00;
    @(negedge clk);
    data_valid = 1'b0; cmd_end = 1'b1;
    @(negedge clk);
    cmd_end = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(busy == 1'b0, "R9 stray pulses ignored", int'(busy), 0);
    end
    for (int i = 0; i < NP*PB; i++) sent[i] = 0;
    check_all();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule